// File: doc/BRIEF.md
# Asynchronous SRAM Write-Cycle Controller

This block turns a simple request/ready handshake into complete write cycles on a parallel asynchronous static RAM. It runs on a single system clock. The clock period in nanoseconds is a parameter. A speed-grade parameter selects the memory's nanosecond minimums. Each minimum is turned into a whole number of clock cycles by rounding up. The controller drives the address bus, the write data with its tristate enable, and the active-low chip select, write enable and output enable.

A write happens while chip select and write enable are both low. A mode parameter picks which of the two rises first to end the write. The other one follows one cycle later. By default, output enable is held high for the whole write. A second option keeps output enable low instead. In that case the controller waits for the memory's output turn-off time before it drives the data bus. The ready output stays low long enough that back-to-back requests always respect the memory's minimum cycle time.

All figures in the requirements use the defaults: a 4 ns clock and the 55 ns grade. With these, the grade minimums round up to:

| Interval | Minimum | Cycles |
|---|---|---|
| Write enable low pulse | 40 ns | 10 |
| Address valid before write end | 45 ns | 12 |
| Chip select low before write end | 45 ns | 12 |
| Data setup before write end | 25 ns | 7 |
| Output turn-off after write enable falls | 20 ns | 5 |
| Full write cycle | 55 ns | 14 |

Top module: `sram_wr_ctrl`

## Requirements
- R1: After reset is asserted, and for as long as it is held: rdy_o is 1, mem_cs_no is 1, mem_we_no is 1 and mem_data_oe_o is 0. This holds even if reset arrives in the middle of a write.
- R2: A request is accepted on a rising clock edge where both req_i and rdy_o are 1. From the next cycle, rdy_o is 0, and mem_addr_o and mem_data_o carry the addr_i and wdata_i values sampled at that edge.
- R3: For every write, the cycle after acceptance starts an overlap in which mem_cs_no and mem_we_no are both 0. The overlap lasts exactly N_WR cycles. N_WR is the largest of: the write-enable pulse count, the address-setup count, the chip-select-setup count, and the data-setup count. In output-enable-low mode, the data-setup count is increased by the turn-off count. With the defaults, N_WR is 12 in both modes.
- R4: In write-enable-terminated mode (CS_END=0), mem_we_no rises first. mem_cs_no stays 0 for exactly one more cycle, then rises.
- R5: In chip-select-terminated mode (CS_END=1), mem_cs_no rises first. mem_we_no stays 0 for exactly one more cycle, then rises.
- R6: mem_data_oe_o is 1 only during the overlap. It drops on the same clock edge that ends the overlap.
- R7: With OE_KEEP_LOW=0, mem_oe_no is always 1, and mem_data_oe_o is 1 for every overlap cycle. With OE_KEEP_LOW=1, mem_oe_no is always 0, and mem_data_oe_o stays 0 for the first 5 overlap cycles. It is then 1 for the remaining 7 or more overlap cycles.
- R8: After acceptance, rdy_o is 0 for 13 cycles and 1 in the 14th. mem_addr_o and mem_data_o do not change while rdy_o is 0.
- R9: A req_i held at 1 while rdy_o is 0 is ignored, along with any addr_i and wdata_i changes in that time. No extra overlap occurs, and the bus values stay those of the accepted request.
- R10: With req_i held at 1 continuously, successive acceptances are exactly 14 cycles apart. mem_addr_o changes to the second address in the cycle in which the second overlap begins.
- R11: The address and data of each write reach the memory bus unchanged for every bit pattern, including all zeros and all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request |
| addr_i | input | ADDR_W | Write address |
| wdata_i | input | DATA_W | Write data |
| rdy_o | output | 1 | Controller can accept a request |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_data_o | output | DATA_W | Data to drive onto the memory data bus |
| mem_data_oe_o | output | 1 | Data-bus tristate enable, high drives |
| mem_cs_no | output | 1 | Memory chip select, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |

## Verification
The main write path is exercised with several patterns:
- Address/data patterns that are all zeros, all ones, and alternating bits. These show whether any bus bit is stuck or swapped.
- Idle gaps of zero to five cycles between writes. These show that the cycle count restarts cleanly from idle.
- Requests held high while addr_i and wdata_i toggle during a write. These separate a correctly captured transaction from one that leaks later inputs or starts a second write.

Two instances run the same stimulus side by side. One is write-enable terminated with output enable high. The other is chip-select terminated with output enable low. Comparing them checks which strobe ends the write, and the delayed data enable.

Directed runs cover reset in the middle of a write and a continuous request. The continuous request pins down the exact spacing between acceptances.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_TERM  = 2'd2,
    PH_PAD   = 2'd3
  } phase_e;

  // nanosecond minimums of one speed grade
  typedef struct packed {
    int unsigned cyc;       // address to address
    int unsigned cs_lead;   // chip select low before write end
    int unsigned addr_lead; // address valid before write end
    int unsigned we_pulse;  // write enable low width
    int unsigned d_setup;   // data valid before write end
    int unsigned q_off;     // memory output turn-off after we falls
  } tim_ns_t;

  function automatic tim_ns_t grade_ns(input int unsigned grade);
    tim_ns_t t;
    case (grade)
      35:      t = '{cyc: 35, cs_lead: 25, addr_lead: 25, we_pulse: 25, d_setup: 20, q_off: 10};
      45:      t = '{cyc: 45, cs_lead: 35, addr_lead: 35, we_pulse: 35, d_setup: 20, q_off: 20};
      default: t = '{cyc: 55, cs_lead: 45, addr_lead: 45, we_pulse: 40, d_setup: 25, q_off: 20};
    endcase
    return t;
  endfunction

  // ceiling division; any nonzero interval gets at least one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned p;
    p = (per == 0) ? 1 : per;
    if (ns == 0) return 0;
    return (ns + p - 1) / p;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int unsigned WR_CYC  = 12,
  parameter int unsigned PAD_CYC = 0,
  parameter int unsigned CNT_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  output logic             rdy_o,
  output logic             load_o,
  output phase_e           ph_d_o,
  output logic [CNT_W-1:0] cnt_d_o
);

  localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] PAD_LAST = CNT_W'(PAD_CYC - 1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    load_o = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_i) begin
          load_o = 1'b1;
          ph_d   = PH_WRITE;
          cnt_d  = '0;
        end
      end
      PH_WRITE: begin
        if (cnt_q == WR_LAST) begin
          ph_d  = PH_TERM;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_TERM: begin
        ph_d  = (PAD_CYC > 0) ? PH_PAD : PH_IDLE;
        cnt_d = '0;
      end
      PH_PAD: begin
        if (cnt_q == PAD_LAST) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign rdy_o   = (ph_q == PH_IDLE);
  assign ph_d_o  = ph_d;
  assign cnt_d_o = cnt_d;

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter bit          CS_END      = 1'b0,
  parameter bit          OE_KEEP_LOW = 1'b0,
  parameter int unsigned HZ_CYC      = 5,
  parameter int unsigned CNT_W       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           ph_d_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  output logic             cs_no,
  output logic             we_no,
  output logic             oe_no,
  output logic             data_oe_o
);

  logic wr_d, term_d;
  logic cs_n_d, we_n_d, doe_d;

  assign wr_d   = (ph_d_i == PH_WRITE);
  assign term_d = (ph_d_i == PH_TERM);

  // the strobe that ends the write rises on entry to PH_TERM, the other one cycle later
  if (CS_END) begin : g_cs_end
    assign cs_n_d = ~wr_d;
    assign we_n_d = ~(wr_d | term_d);
  end else begin : g_we_end
    assign cs_n_d = ~(wr_d | term_d);
    assign we_n_d = ~wr_d;
  end

  if (OE_KEEP_LOW) begin : g_oe_low
    assign doe_d = wr_d & (cnt_d_i >= CNT_W'(HZ_CYC));
    assign oe_no = 1'b0;
  end else begin : g_oe_high
    assign doe_d = wr_d;
    assign oe_no = 1'b1;
  end

  // registered strobes: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_no     <= 1'b1;
      we_no     <= 1'b1;
      data_oe_o <= 1'b0;
    end else begin
      cs_no     <= cs_n_d;
      we_no     <= we_n_d;
      data_oe_o <= doe_d;
    end
  end

endmodule

// File: rtl/sram_wr_dpath.sv
module sram_wr_dpath #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      data_o <= '0;
    end else if (load_i) begin
      addr_o <= addr_i;
      data_o <= wdata_i;
    end
  end

endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_wr_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned SPEED_GRADE   = 55,
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 8,
  parameter bit          CS_END        = 1'b0,
  parameter bit          OE_KEEP_LOW   = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rdy_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              mem_data_oe_o,
  output logic              mem_cs_no,
  output logic              mem_we_no,
  output logic              mem_oe_no
);

  localparam tim_ns_t     TIM     = grade_ns(SPEED_GRADE);
  localparam int unsigned CYC_C   = ns_to_cyc(TIM.cyc,       CLK_PERIOD_NS);
  localparam int unsigned CSL_C   = ns_to_cyc(TIM.cs_lead,   CLK_PERIOD_NS);
  localparam int unsigned ADL_C   = ns_to_cyc(TIM.addr_lead, CLK_PERIOD_NS);
  localparam int unsigned PWE_C   = ns_to_cyc(TIM.we_pulse,  CLK_PERIOD_NS);
  localparam int unsigned DSU_C   = ns_to_cyc(TIM.d_setup,   CLK_PERIOD_NS);
  localparam int unsigned HZ_CYC  = OE_KEEP_LOW ? ns_to_cyc(TIM.q_off, CLK_PERIOD_NS) : 0;
  localparam int unsigned DWIN_C  = HZ_CYC + DSU_C;
  localparam int unsigned WR_CYC  = umax(umax(umax(PWE_C, ADL_C), umax(CSL_C, DWIN_C)), 1);
  // write + terminate + one idle accept cycle must cover the full cycle time
  localparam int unsigned TOT_CYC = umax(CYC_C, WR_CYC + 2);
  localparam int unsigned PAD_CYC = TOT_CYC - WR_CYC - 2;
  localparam int unsigned CNT_W   = $clog2(umax(WR_CYC, PAD_CYC) + 1);

  logic             load;
  phase_e           ph_d;
  logic [CNT_W-1:0] cnt_d;

  sram_wr_seq #(
    .WR_CYC (WR_CYC),
    .PAD_CYC(PAD_CYC),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .rdy_o  (rdy_o),
    .load_o (load),
    .ph_d_o (ph_d),
    .cnt_d_o(cnt_d)
  );

  sram_wr_pins #(
    .CS_END     (CS_END),
    .OE_KEEP_LOW(OE_KEEP_LOW),
    .HZ_CYC     (HZ_CYC),
    .CNT_W      (CNT_W)
  ) u_pins (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ph_d_i   (ph_d),
    .cnt_d_i  (cnt_d),
    .cs_no    (mem_cs_no),
    .we_no    (mem_we_no),
    .oe_no    (mem_oe_no),
    .data_oe_o(mem_data_oe_o)
  );

  sram_wr_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .addr_o (mem_addr_o),
    .data_o (mem_data_o)
  );

endmodule

// File: rtl/sram_wr_ctrl_chk.sv
module sram_wr_ctrl_chk #(
  parameter int unsigned ADDR_W      = 19,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WR_CYC      = 12,
  parameter int unsigned HZ_CYC      = 0,
  parameter bit          OE_KEEP_LOW = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              rdy_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_data_o,
  input logic              mem_data_oe_o,
  input logic              mem_cs_no,
  input logic              mem_we_no
);

  logic        ovl;
  logic [15:0] ovl_cnt;

  assign ovl = ~mem_cs_no & ~mem_we_no;

  // overlap cycles seen so far in the current write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ovl_cnt <= '0;
    else if (ovl) ovl_cnt <= ovl_cnt + 1'b1;
    else          ovl_cnt <= '0;
  end

  AST_ACCEPT_DROPS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && rdy_o |=> !rdy_o); // R2

  AST_OVERLAP_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovl && $past(ovl) |-> ovl_cnt == 16'(WR_CYC)); // R3

  AST_SINGLE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovl && $past(ovl) |-> (mem_cs_no ^ mem_we_no)); // R4 R5

  AST_DATA_IN_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_data_oe_o |-> ovl); // R6

  AST_BUS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o && $past(!rdy_o) |-> $stable(mem_addr_o) && $stable(mem_data_o)); // R8

  if (OE_KEEP_LOW) begin : g_oe_low
    AST_TURNOFF_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(mem_data_oe_o) |-> ovl_cnt == 16'(HZ_CYC)); // R7
  end else begin : g_oe_high
    AST_DRIVE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(mem_data_oe_o) |-> ovl_cnt == 16'd0); // R7
  end

endmodule

bind sram_wr_ctrl sram_wr_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .WR_CYC     (WR_CYC),
  .HZ_CYC     (HZ_CYC),
  .OE_KEEP_LOW(OE_KEEP_LOW)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .rdy_o        (rdy_o),
  .mem_addr_o   (mem_addr_o),
  .mem_data_o   (mem_data_o),
  .mem_data_oe_o(mem_data_oe_o),
  .mem_cs_no    (mem_cs_no),
  .mem_we_no    (mem_we_no)
);

// File: tb/sram_wr_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_wr_ctrl_tb_top;

  localparam int AW  = 19;
  localparam int DW  = 8;
  localparam int PER = 4;
  localparam int WIN = 15;

  function automatic int cdiv(input int ns);
    return (ns + PER - 1) / PER;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // expectations from the 55 ns grade minimums
  localparam int E_HZ  = cdiv(20);
  localparam int E_SD  = cdiv(25);
  localparam int E_WRA = imax(imax(cdiv(40), cdiv(45)), imax(cdiv(45), E_SD));
  localparam int E_WRB = imax(E_WRA, E_HZ + E_SD);
  localparam int E_CYC = imax(cdiv(55), E_WRA + 2);

  // {addr, data, idle gap, hold request with toggling inputs}
  localparam logic [31:0] VEC [6] = '{
    {19'h00000, 8'h00, 4'd1, 1'b0},
    {19'h7FFFF, 8'hFF, 4'd0, 1'b0},
    {19'h55555, 8'hAA, 4'd3, 1'b1},
    {19'h2AAAA, 8'h55, 4'd0, 1'b0},
    {19'h12345, 8'h5A, 4'd2, 1'b1},
    {19'h40001, 8'h81, 4'd5, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;

  logic          rdy [2];
  logic [AW-1:0] maddr [2];
  logic [DW-1:0] mdata [2];
  logic          doe [2], csn [2], wen [2], oen [2];

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  sram_wr_ctrl #(.CLK_PERIOD_NS(PER), .SPEED_GRADE(55), .ADDR_W(AW), .DATA_W(DW),
                 .CS_END(1'b0), .OE_KEEP_LOW(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .addr_i(addr), .wdata_i(wdata),
    .rdy_o(rdy[0]), .mem_addr_o(maddr[0]), .mem_data_o(mdata[0]),
    .mem_data_oe_o(doe[0]), .mem_cs_no(csn[0]), .mem_we_no(wen[0]), .mem_oe_no(oen[0]));

  sram_wr_ctrl #(.CLK_PERIOD_NS(PER), .SPEED_GRADE(55), .ADDR_W(AW), .DATA_W(DW),
                 .CS_END(1'b1), .OE_KEEP_LOW(1'b1)) dut_b_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .addr_i(addr), .wdata_i(wdata),
    .rdy_o(rdy[1]), .mem_addr_o(maddr[1]), .mem_data_o(mdata[1]),
    .mem_data_oe_o(doe[1]), .mem_cs_no(csn[1]), .mem_we_no(wen[1]), .mem_oe_no(oen[1]));

  logic [WIN-1:0] s_cs [2], s_we [2], s_doe [2], s_rdy [2], s_oen [2], s_aok [2], s_dok [2];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  task automatic sample(input int k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    for (int u = 0; u < 2; u++) begin
      s_cs[u][k]  = csn[u];
      s_we[u][k]  = wen[u];
      s_doe[u][k] = doe[u];
      s_rdy[u][k] = rdy[u];
      s_oen[u][k] = oen[u];
      s_aok[u][k] = (maddr[u] == a);
      s_dok[u][k] = (mdata[u] == d);
    end
  endtask

  task automatic analyze(input int u, input string dtag);
    logic [WIN-1:0] e_cs, e_we, e_doe, e_rdy, e_oen;
    int ewr, ovl;
    ewr = (u == 0) ? E_WRA : E_WRB;
    ovl = 0;
    for (int k = 0; k < WIN; k++) begin
      e_cs[k]  = (k < ewr) ? 1'b0 : (k == ewr) ? (u == 1) : 1'b1;
      e_we[k]  = (k < ewr) ? 1'b0 : (k == ewr) ? (u == 0) : 1'b1;
      e_doe[k] = (k < ewr) && (u == 0 || k >= E_HZ);
      e_rdy[k] = (k >= E_CYC - 1);
      e_oen[k] = (u == 0);
      if (!s_cs[u][k] && !s_we[u][k]) ovl++;
    end
    chk(ovl == ewr, "R3 overlap length", ovl, ewr);
    chk(s_cs[u] == e_cs, (u == 0) ? "R4 cs_n trace" : "R5 cs_n trace", s_cs[u], e_cs);
    chk(s_we[u] == e_we, (u == 0) ? "R4 we_n trace" : "R5 we_n trace", s_we[u], e_we);
    chk(s_doe[u] == e_doe, "R6/R7 data enable trace", s_doe[u], e_doe);
    chk(s_oen[u] == e_oen, "R7 oe_n trace", s_oen[u], e_oen);
    chk(s_rdy[u] == e_rdy, "R8 ready trace", s_rdy[u], e_rdy);
    chk(&s_aok[u], {dtag, " address on bus"}, s_aok[u], {WIN{1'b1}});
    chk(&s_dok[u], {dtag, " data on bus"}, s_dok[u], {WIN{1'b1}});
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [AW-1:0] va;
    logic [DW-1:0] vd;
    int k2;
    bit seen;

    // R1: reset state
    repeat (3) @(negedge clk);
    for (int u = 0; u < 2; u++)
      chk(rdy[u] && csn[u] && wen[u] && !doe[u], "R1 reset state",
          {rdy[u], csn[u], wen[u], doe[u]}, 4'b1110);
    rst_ni = 1'b1;
    @(negedge clk);

    // table walk: R2, R3..R8, R9 (held/toggled request), R11 (patterns)
    for (int v = 0; v < 6; v++) begin
      va = VEC[v][31:13];
      vd = VEC[v][12:5];
      repeat (int'(VEC[v][4:1])) @(negedge clk);
      chk(rdy[0] && rdy[1], "R2 ready before request", {rdy[0], rdy[1]}, 2'b11);
      req = 1'b1;
      addr = va;
      wdata = vd;
      @(negedge clk);
      for (int k = 0; k < WIN; k++) begin
        sample(k, va, vd);
        if (VEC[v][0] && k < E_WRA) begin
          req = 1'b1;
          addr = ~va ^ AW'(k);
          wdata = ~vd;
        end else begin
          req = 1'b0;
        end
        if (k < WIN - 1) @(negedge clk);
      end
      analyze(0, VEC[v][0] ? "R9" : "R11");
      analyze(1, VEC[v][0] ? "R9" : "R11");
    end

    // R1: reset in the middle of a write
    req = 1'b1;
    addr = 19'h0F0F0;
    wdata = 8'h3C;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    chk(!csn[0] && !wen[0], "R1 write in progress before reset", {csn[0], wen[0]}, 2'b00);
    rst_ni = 1'b0;
    #1;
    for (int u = 0; u < 2; u++)
      chk(rdy[u] && csn[u] && wen[u] && !doe[u], "R1 reset mid-write",
          {rdy[u], csn[u], wen[u], doe[u]}, 4'b1110);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R10: continuous request, spacing between acceptances
    req = 1'b1;
    addr = 19'h11111;
    wdata = 8'h11;
    @(negedge clk);
    addr = 19'h22222;
    wdata = 8'h22;
    k2 = 0;
    seen = 1'b0;
    for (int k = 1; k < 40 && !seen; k++) begin
      @(negedge clk);
      if (maddr[0] == 19'h22222) begin
        seen = 1'b1;
        k2 = k;
      end
    end
    req = 1'b0;
    chk(k2 == E_CYC, "R10 acceptance spacing", k2, E_CYC);
    chk(!csn[0] && !wen[0] && !csn[1] && !wen[1], "R10 second overlap starts with new address",
        {csn[0], wen[0], csn[1], wen[1]}, 4'b0000);
    chk(mdata[1] == 8'h22, "R10 second data", mdata[1], 8'h22);
    repeat (20) @(negedge clk);
    chk(rdy[0] && rdy[1] && csn[0] && wen[1], "R10 returns idle",
        {rdy[0], rdy[1], csn[0], wen[1]}, 4'b1111);

    finish_run();
  end

endmodule